// File: doc/BRIEF.md
# Catch-Word Chip Failure Recovery

This block models a nine-chip ECC memory rank together with the controller logic that reads it. A 64-byte line is split into eight 64-bit words, one per data chip, and a ninth chip keeps the bitwise XOR of those eight words. Every data chip owns a private 64-bit marker value. When a chip's on-die checker flags a problem on a read, that chip returns its marker on the same burst instead of its stored word. No extra pins or burst beats carry the error status.

The controller side recomputes parity over the eight returned words. If parity holds, the line passes through unchanged. If parity fails and exactly one chip returned its own marker, that chip is taken as failed and its word is rebuilt from the parity word and the other seven words. Any other parity failure is reported as detected but uncorrectable. Each write compares the incoming words against the markers. A marker that equals the word its chip has just stored is advanced one LFSR step, so a chip's stored data and its marker never match at the moment of storage.

A three-state machine sequences the work. ST_IDLE accepts requests. ST_WR_SCAN is entered from ST_IDLE when a write is accepted and spends one cycle checking markers for collisions. ST_RD_EVAL is entered from ST_IDLE when a read is accepted without a write and spends one cycle on location and repair. Both busy states return to ST_IDLE unconditionally.

Top module: `cw_recover`

## Requirements
- R1: Bits [64*i+63 : 64*i] of `wr_line` and `rd_line` belong to data chip i (i = 0..7). Flag bit i of `rd_err_flags` belongs to the same chip. The parity chip stores the XOR of the eight words.
- R2: A write is accepted on a rising edge where `ready` and `wr_en` are high. `ready` is low for the following cycle and high again after it.
- R3: A read is accepted on a rising edge where `ready` and `rd_en` are high and `wr_en` is low. `rd_valid` is high for exactly one cycle, following the second rising edge after acceptance. `ready` is low between acceptance and that edge, and requests are ignored while `ready` is low.
- R4: A read with no flags returns the written line, with `rd_corrected` = 0, `rd_uncorr` = 0 and `rd_chip` = 0.
- R5: A read with exactly one flag set, on chip k, returns the written line with `rd_corrected` = 1 and `rd_chip` = k.
- R6: A read with two or more flags set gives `rd_uncorr` = 1, `rd_corrected` = 0 and `rd_chip` = 0, and `rd_line` carries the raw returned words.
- R7: After reset, chip i's marker is CW_SEED + (i+1)*64'h0101_0101_0101_0101. If a write stores a word equal to chip i's marker, the marker advances once to v[0] ? (v>>1) ^ 64'hD800_0000_0000_0000 : (v>>1). After the write completes, no data chip's marker equals the word it just stored.
- R8: If `wr_en` and `rd_en` are both high while `ready`, only the write is performed, and no read result follows.
- R9: While reset is held and after it is released, `ready` = 1 and `rd_valid`, `rd_corrected`, `rd_uncorr` and `rd_chip` are 0 until a read completes.
- R10: When `rd_valid` is low, `rd_corrected`, `rd_uncorr` and `rd_chip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Line address for write |
| wr_line | input | 512 | Line to store, eight 64-bit chip words |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Line address for read |
| rd_err_flags | input | 8 | On-die error flags, one per data chip, taken with the read |
| ready | output | 1 | Block idle and able to accept a request |
| rd_valid | output | 1 | Read result present this cycle |
| rd_line | output | 512 | Returned, possibly repaired, line |
| rd_corrected | output | 1 | One chip was located and rebuilt |
| rd_uncorr | output | 1 | Parity failed and the failed chip could not be identified |
| rd_chip | output | 3 | Index of the rebuilt chip |

## Verification
The hardest case to reach from the ports is a collision, where a write stores a word equal to a chip's current marker. The marker is internal and changes with each collision, so random data never hits it. The bench keeps its own copy of the marker sequence, which it derives from the reset formula and the step rule. It writes lines whose chosen words equal the predicted marker, for one chip and for several chips at once, and repeats this on the advanced values. It then reads those lines with the matching flag raised and expects a clean single-chip repair. A marker that failed to advance would leave parity intact, so the read would come back unrepaired.

// File: rtl/cw_recover_pkg.sv
package cw_recover_pkg;
    localparam int WORD_W = 64;
    localparam int N_DATA = 8;
    localparam int N_CHIP = N_DATA + 1;
    localparam int IDX_W  = $clog2(N_DATA);
    localparam int LINE_W = WORD_W * N_DATA;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_SCAN,
        ST_RD_EVAL
    } cw_state_t;

    localparam word_t LFSR_TAPS  = 64'hD800_0000_0000_0000;
    localparam word_t SEED_SPACE = 64'h0101_0101_0101_0101;

    // one Galois step of the marker generator
    function automatic word_t cw_step(input word_t v);
        return v[0] ? ((v >> 1) ^ LFSR_TAPS) : (v >> 1);
    endfunction

    // reset value of the marker held by data chip idx
    function automatic word_t cw_seed(input word_t base, input int idx);
        return base + (word_t'(idx + 1) * SEED_SPACE);
    endfunction
endpackage

// File: rtl/cw_bank.sv
module cw_bank
    import cw_recover_pkg::*;
#(
    parameter word_t CW_SEED = 64'hC3A5_96E1_0F2D_B478
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_DATA-1:0]             bump,
    output logic [N_DATA-1:0][WORD_W-1:0] cw_o
);
    for (genvar i = 0; i < N_DATA; i++) begin : g_marker
        word_t mark_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark_q <= cw_seed(CW_SEED, i);
            end else if (bump[i]) begin
                mark_q <= cw_step(mark_q);
            end
        end
        assign cw_o[i] = mark_q;
    end
endmodule

// File: rtl/cw_store.sv
module cw_store
    import cw_recover_pkg::*;
#(
    parameter int LINES = 16,
    localparam int AW   = $clog2(LINES)
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [N_DATA-1:0][WORD_W-1:0] wr_words,
    input  logic                          rd_en,
    input  logic [AW-1:0]                 rd_addr,
    input  logic [N_DATA-1:0]             flags,
    input  logic [N_DATA-1:0][WORD_W-1:0] cw,
    output logic [N_CHIP-1:0][WORD_W-1:0] rd_words
);
    word_t                          par_word;
    logic [N_CHIP-1:0][WORD_W-1:0]  chip_in;
    logic [N_CHIP-1:0][WORD_W-1:0]  chip_mark;
    logic [N_CHIP-1:0]              chip_flag;

    always_comb begin
        par_word = '0;
        for (int i = 0; i < N_DATA; i++) begin
            par_word = par_word ^ wr_words[i];
        end
    end

    assign chip_in   = {par_word, wr_words};
    assign chip_mark = {word_t'(0), cw};
    assign chip_flag = {1'b0, flags};

    for (genvar c = 0; c < N_CHIP; c++) begin : g_chip
        word_t cells [LINES];
        word_t out_q;
        always_ff @(posedge clk) begin
            if (wr_en) begin
                cells[wr_addr] <= chip_in[c];
            end
            if (rd_en) begin
                out_q <= chip_flag[c] ? chip_mark[c] : cells[rd_addr];
            end
        end
        assign rd_words[c] = out_q;
    end
endmodule

// File: rtl/cw_locate.sv
module cw_locate
    import cw_recover_pkg::*;
(
    input  logic [N_CHIP-1:0][WORD_W-1:0] words,
    input  logic [N_DATA-1:0][WORD_W-1:0] cw,
    output logic [N_DATA-1:0][WORD_W-1:0] fixed,
    output logic                          corrected,
    output logic                          uncorr,
    output logic [IDX_W-1:0]              chip
);
    localparam int CNT_W = $clog2(N_DATA + 1);

    word_t               syndrome;
    logic [N_DATA-1:0]   hit;
    logic [CNT_W-1:0]    hits;
    logic                mismatch;

    for (genvar i = 0; i < N_DATA; i++) begin : g_hit
        assign hit[i] = (words[i] == cw[i]);
    end

    always_comb begin
        syndrome = words[N_DATA];
        for (int i = 0; i < N_DATA; i++) begin
            syndrome = syndrome ^ words[i];
        end
        mismatch  = |syndrome;
        hits      = CNT_W'($countones(hit));
        corrected = mismatch && (hits == CNT_W'(1));
        uncorr    = mismatch && (hits != CNT_W'(1));
        chip      = '0;
        for (int i = 0; i < N_DATA; i++) begin
            if (corrected && hit[i]) begin
                chip = IDX_W'(i);
            end
        end
        for (int i = 0; i < N_DATA; i++) begin
            fixed[i] = (corrected && hit[i]) ? (words[i] ^ syndrome) : words[i];
        end
    end
endmodule

// File: rtl/cw_recover.sv
module cw_recover
    import cw_recover_pkg::*;
#(
    parameter int    LINES   = 16,
    parameter word_t CW_SEED = 64'hC3A5_96E1_0F2D_B478,
    localparam int   AW      = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic [N_DATA-1:0] rd_err_flags,
    output logic              ready,
    output logic              rd_valid,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_corrected,
    output logic              rd_uncorr,
    output logic [IDX_W-1:0]  rd_chip
);
    cw_state_t state_q, state_d;

    logic                          take_wr;
    logic                          take_rd;
    logic                          scan_phase;
    logic [N_DATA-1:0]             bump;
    logic [N_DATA-1:0][WORD_W-1:0] cw_q;
    logic [N_DATA-1:0][WORD_W-1:0] wr_words;
    logic [N_DATA-1:0][WORD_W-1:0] wr_hold_q;
    logic [N_CHIP-1:0][WORD_W-1:0] got_words;
    logic [N_DATA-1:0][WORD_W-1:0] fixed_words;
    logic                          fix_ok;
    logic                          fix_bad;
    logic [IDX_W-1:0]              fix_chip;

    assign ready      = (state_q == ST_IDLE);
    assign take_wr    = ready && wr_en;
    assign take_rd    = ready && rd_en && !wr_en;
    assign scan_phase = (state_q == ST_WR_SCAN);
    assign wr_words   = wr_line;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_wr) begin
                    state_d = ST_WR_SCAN;
                end else if (take_rd) begin
                    state_d = ST_RD_EVAL;
                end
            end
            ST_WR_SCAN: state_d = ST_IDLE;
            ST_RD_EVAL: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // held copy of the last written words for the collision scan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_hold_q <= '0;
        end else if (take_wr) begin
            wr_hold_q <= wr_words;
        end
    end

    for (genvar i = 0; i < N_DATA; i++) begin : g_bump
        assign bump[i] = scan_phase && (wr_hold_q[i] == cw_q[i]);
    end

    cw_bank #(
        .CW_SEED (CW_SEED)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .cw_o  (cw_q)
    );

    cw_store #(
        .LINES (LINES)
    ) u_store (
        .clk      (clk),
        .wr_en    (take_wr),
        .wr_addr  (wr_addr),
        .wr_words (wr_words),
        .rd_en    (take_rd),
        .rd_addr  (rd_addr),
        .flags    (rd_err_flags),
        .cw       (cw_q),
        .rd_words (got_words)
    );

    cw_locate u_locate (
        .words     (got_words),
        .cw        (cw_q),
        .fixed     (fixed_words),
        .corrected (fix_ok),
        .uncorr    (fix_bad),
        .chip      (fix_chip)
    );

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_line      <= '0;
            rd_corrected <= 1'b0;
            rd_uncorr    <= 1'b0;
            rd_chip      <= '0;
        end else if (state_q == ST_RD_EVAL) begin
            rd_valid     <= 1'b1;
            rd_line      <= fixed_words;
            rd_corrected <= fix_ok;
            rd_uncorr    <= fix_bad;
            rd_chip      <= fix_chip;
        end else begin
            rd_valid     <= 1'b0;
            rd_corrected <= 1'b0;
            rd_uncorr    <= 1'b0;
            rd_chip      <= '0;
        end
    end
endmodule

// File: rtl/cw_recover_chk.sv
module cw_recover_chk
    import cw_recover_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic                          rd_en,
    input logic                          ready,
    input logic                          rd_valid,
    input logic                          rd_corrected,
    input logic                          rd_uncorr,
    input logic [IDX_W-1:0]              rd_chip,
    input logic                          scan_phase,
    input logic [N_DATA-1:0][WORD_W-1:0] cw_now,
    input logic [N_DATA-1:0][WORD_W-1:0] hold
);
    // R3
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rd_en && !wr_en) |-> ##2 rd_valid);

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R2
    write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en) |=> (!ready ##1 ready));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && wr_en && rd_en) |=> ##1 !rd_valid);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_corrected && rd_uncorr));

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!rd_corrected && !rd_uncorr && rd_chip == '0));

    for (genvar i = 0; i < N_DATA; i++) begin : g_mark
        // R7
        mark_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
            scan_phase |=> (cw_now[i] != hold[i]));
    end
endmodule

bind cw_recover cw_recover_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .ready        (ready),
    .rd_valid     (rd_valid),
    .rd_corrected (rd_corrected),
    .rd_uncorr    (rd_uncorr),
    .rd_chip      (rd_chip),
    .scan_phase   (scan_phase),
    .cw_now       (cw_q),
    .hold         (wr_hold_q)
);

// File: tb/cw_recover_test.sv
module cw_recover_test;
    localparam int LINES = 16;
    localparam int AW    = $clog2(LINES);
    localparam logic [63:0] SEED = 64'hC3A5_96E1_0F2D_B478;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [511:0] wr_line = '0;
    logic         rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]   rd_err_flags = '0;
    logic         ready;
    logic         rd_valid;
    logic [511:0] rd_line;
    logic         rd_corrected;
    logic         rd_uncorr;
    logic [2:0]   rd_chip;

    always #5 clk = ~clk;

    cw_recover #(.LINES(LINES), .CW_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_line(wr_line),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_err_flags(rd_err_flags), .ready(ready),
        .rd_valid(rd_valid), .rd_line(rd_line), .rd_corrected(rd_corrected),
        .rd_uncorr(rd_uncorr), .rd_chip(rd_chip)
    );

    int vectors = 0;
    int fails = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // behavioural reference model
    logic [511:0] m_mem [LINES];
    logic [63:0]  m_cw [8];
    logic [511:0] m_hold;
    int           m_state = 0;
    string        m_tag = "R9";
    logic [511:0] p_line;
    bit           p_corr, p_unc;
    int           p_chip;
    string        p_tag;
    bit           e_ready = 1'b1, e_valid = 1'b0, e_corr = 1'b0, e_unc = 1'b0;
    logic [511:0] e_line = '0;
    int           e_chip = 0;
    string        e_tag = "R9";

    function automatic logic [63:0] step(input logic [63:0] v);
        return v[0] ? ((v >> 1) ^ 64'hD800_0000_0000_0000) : (v >> 1);
    endfunction

    task automatic check(input string tag, input string what, input logic [511:0] act, input logic [511:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic predict_read(input int a, input logic [7:0] f);
        logic [63:0] w [8];
        logic [63:0] par, syn;
        int hits, idx;
        par = 64'h0;
        for (int i = 0; i < 8; i++) par ^= m_mem[a][64*i +: 64];
        syn = par;
        hits = 0;
        idx = 0;
        for (int i = 0; i < 8; i++) begin
            w[i] = f[i] ? m_cw[i] : m_mem[a][64*i +: 64];
            syn ^= w[i];
        end
        for (int i = 0; i < 8; i++) if (w[i] == m_cw[i]) begin hits++; idx = i; end
        p_corr = (syn != 0) && (hits == 1);
        p_unc  = (syn != 0) && (hits != 1);
        p_chip = p_corr ? idx : 0;
        for (int i = 0; i < 8; i++)
            p_line[64*i +: 64] = (p_corr && i == idx) ? (w[i] ^ syn) : w[i];
        p_tag = m_tag;
    endtask

    always @(negedge clk) begin
        if (rst_n && running) begin
            check(m_tag, "ready", 512'(ready), 512'(e_ready));
            check(e_valid ? e_tag : m_tag, "rd_valid", 512'(rd_valid), 512'(e_valid));
            if (e_valid) begin
                check(e_tag, "rd_line", rd_line, e_line);
                check(e_tag, "rd_corrected", 512'(rd_corrected), 512'(e_corr));
                check(e_tag, "rd_uncorr", 512'(rd_uncorr), 512'(e_unc));
                check(e_tag, "rd_chip", 512'(rd_chip), 512'(e_chip));
            end else begin
                // R10 flags quiet without a result
                check("R10", "idle flags", {rd_corrected, rd_uncorr, rd_chip}, 512'(0));
            end
            // predict the state after the next rising edge
            e_valid = 1'b0;
            if (m_state == 0) begin
                if (wr_en) begin
                    m_mem[wr_addr] = wr_line;
                    m_hold = wr_line;
                    m_state = 1;
                    e_ready = 1'b0;
                end else if (rd_en) begin
                    predict_read(int'(rd_addr), rd_err_flags);
                    m_state = 2;
                    e_ready = 1'b0;
                end
            end else if (m_state == 1) begin
                for (int i = 0; i < 8; i++)
                    if (m_hold[64*i +: 64] == m_cw[i]) m_cw[i] = step(m_cw[i]);
                m_state = 0;
                e_ready = 1'b1;
            end else begin
                e_valid = 1'b1;
                e_line = p_line;
                e_corr = p_corr;
                e_unc = p_unc;
                e_chip = p_chip;
                e_tag = p_tag;
                m_state = 0;
                e_ready = 1'b1;
            end
        end
    end

    function automatic logic [511:0] rnd_line();
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[32*i +: 32] = $urandom;
        return l;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_idle();
        while (!ready) tick();
    endtask

    task automatic do_write(input int a, input logic [511:0] l, input string tag);
        wait_idle();
        m_tag = tag;
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_line = l;
        tick();
        wr_en = 1'b0;
        tick();
    endtask

    task automatic do_read(input int a, input logic [7:0] f, input string tag);
        wait_idle();
        m_tag = tag;
        rd_en = 1'b1;
        rd_addr = AW'(a);
        rd_err_flags = f;
        tick();
        rd_en = 1'b0;
        rd_err_flags = '0;
        tick();
        tick();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog act=hung exp=finished");
        summary();
    end

    initial begin
        logic [511:0] l;
        for (int i = 0; i < 8; i++) m_cw[i] = SEED + 64'(i + 1) * 64'h0101_0101_0101_0101;
        for (int i = 0; i < LINES; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R9 outputs during reset
        check("R9", "reset ready", 512'(ready), 512'(1));
        check("R9", "reset valid", {rd_valid, rd_corrected, rd_uncorr, rd_chip}, 512'(0));
        rst_n = 1'b1;
        running = 1'b1;
        tick();
        tick();

        // R2 fill lines
        for (int a = 0; a < 8; a++) do_write(a, rnd_line(), "R2");
        do_write(8, {8{64'h0123_4567_89AB_CDEF}}, "R2");

        // R1,R4 clean reads
        for (int a = 0; a < 9; a++) do_read(a, 8'h00, "R1,R4");

        // R5 single flagged chip, every position
        for (int k = 0; k < 8; k++) do_read(k, 8'(1 << k), "R5");
        do_read(8, 8'h80, "R5");

        // R6 two and more flagged chips
        do_read(2, 8'h03, "R6");
        do_read(5, 8'h81, "R6");
        do_read(6, 8'hFF, "R6");

        // R7 single collision, then on the advanced marker
        for (int r = 0; r < 2; r++) begin
            l = rnd_line();
            l[64*3 +: 64] = m_cw[3];
            do_write(10, l, "R7");
            tick();
            do_read(10, 8'h08, "R7");
            do_read(10, 8'h00, "R7");
        end
        // R7 several chips colliding at once
        l = rnd_line();
        l[64*0 +: 64] = m_cw[0];
        l[64*5 +: 64] = m_cw[5];
        l[64*7 +: 64] = m_cw[7];
        do_write(11, l, "R7");
        tick();
        do_read(11, 8'h01, "R7");
        do_read(11, 8'h20, "R7");
        do_read(11, 8'h80, "R7");

        // R8 write and read together
        wait_idle();
        m_tag = "R8";
        wr_en = 1'b1; rd_en = 1'b1;
        wr_addr = AW'(12); rd_addr = AW'(0);
        wr_line = rnd_line();
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        tick(); tick(); tick();
        do_read(12, 8'h00, "R8");

        // R3 request held high across busy cycles
        wait_idle();
        m_tag = "R3";
        rd_en = 1'b1; rd_addr = AW'(4); rd_err_flags = 8'h10;
        repeat (5) tick();
        rd_en = 1'b0; rd_err_flags = '0;
        repeat (3) tick();

        // R3 write request held high across busy cycles
        m_tag = "R3";
        wr_en = 1'b1; wr_addr = AW'(13); wr_line = rnd_line();
        repeat (3) tick();
        wr_en = 1'b0;
        repeat (2) tick();
        do_read(13, 8'h40, "R5");

        repeat (3) tick();
        summary();
    end
endmodule